// File: doc/BRIEF.md
# Interrupt Pending Status Word

This block gathers pending interrupt flags into one 32-bit status word for a processor. There are three internal peripheral requests: a real-time timer, serial-peripheral unit 1 and pulse-width unit 2. There are also five external request pins, which carry the numbers 1, 2, 3, 5 and 6. Every external pin first passes through a synchronizer. Pins 1, 2, 3 and 6 can each be set to one of two modes:

- Level mode: the status bit is a live copy of the synchronized pin.
- Edge mode: a rising edge latches the status bit, and software clears it by writing a 1 to that bit.

Pin 5 always works in level mode.

Besides the word, the block outputs a 3-bit request level, which is the highest priority among all set bits. External pins request at the level equal to their number. The timer and serial unit 1 request at level 4. Pulse-width unit 2 requests at a level that software programs between 1 and 6. Masking and vector generation take place outside this block.

Top module: `irq_status_reg`

## Requirements
- R1: After reset, `status_o` is 0, `prio_o` is 0, every edge flag is clear and the pulse-width level is 6.
- R2: The peripheral requests appear in the same cycle at fixed bit positions: timer at bit 22, serial unit 1 at bit 21, pulse-width unit 2 at bit 13.
- R3: Only bits 22..16 and bit 13 can read as 1. Reserved bits 15 and 14, and all other bits, read 0 even after writing all ones.
- R4: External pin index map of `ext_irq_i`/`edge_mode_i`: index 0 is pin 1 at bit 16, index 1 is pin 2 at bit 17, index 2 is pin 3 at bit 18, index 3 is pin 5 at bit 20, index 4 is pin 6 at bit 19. In level mode (`edge_mode_i` bit 0) the status bit follows the pin two clocks late, and writes do not clear it.
- R5: In edge mode (`edge_mode_i` bit 1) a synchronized rising edge sets the status bit three clocks after the pin rises. The bit stays set after the pin falls.
- R6: A write (`sel_i` and `we_i` high) with a 1 in an edge flag's bit position clears that flag. A 0 in that position, or a write with `sel_i` low, leaves it set.
- R7: If an edge is detected in the same cycle as a clearing write, the flag stays set.
- R8: `prio_o` is the maximum level of the set bits: pin n at level n, timer and serial unit 1 at level 4, pulse-width unit 2 at its programmed level. It is 0 when nothing is pending.
- R9: A strobe on `pwm2_lvl_we_i` loads `pwm2_lvl_i` as the pulse-width level when the value is 1 to 6. The values 0 and 7 are ignored.
- R10: Pin 5 stays in level mode even when `edge_mode_i` bit 3 is set.
- R11: Writes of 1 to bits 22, 21 and 13 do not clear them. These bits follow their request lines only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register select |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data; a 1 clears an edge flag |
| ext_irq_i | input | 5 | External request pins, index map in R4 |
| edge_mode_i | input | 5 | Per pin: 1 selects edge mode, 0 selects level mode |
| rtc_req_i | input | 1 | Real-time timer request |
| spi1_req_i | input | 1 | Serial unit 1 request |
| pwm2_req_i | input | 1 | Pulse-width unit 2 request |
| pwm2_lvl_we_i | input | 1 | Load strobe for the pulse-width level |
| pwm2_lvl_i | input | 3 | New pulse-width level |
| status_o | output | 32 | Pending status word |
| prio_o | output | 3 | Highest pending level, 0 when none |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer, a 3-bit level field and a 32-bit word. With these values the pin-to-status latency is an exact two cycles in level mode and three in edge mode. The bench can therefore sample a known cycle and line up a clearing write with the edge-detect cycle, which exercises the race in R7. Because the pulse-width level spans 1 to 6 inside a 3-bit field, both rejected encodings (0 and 7) can be driven.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int STAT_W   = 32;
  localparam int LVL_W    = 3;
  localparam int NUM_EXT  = 5;
  localparam int NUM_SRC  = NUM_EXT + 3;

  localparam int POS_RTC  = 22;
  localparam int POS_SPI1 = 21;
  localparam int POS_PWM2 = 13;

  // index: pin 1, 2, 3, 5, 6
  localparam int EXT_POS [NUM_EXT] = '{16, 17, 18, 20, 19};
  localparam int EXT_LVL [NUM_EXT] = '{1, 2, 3, 5, 6};
  localparam logic [NUM_EXT-1:0] EXT_EDGE_OK = 5'b10111;

  localparam logic [LVL_W-1:0] RTC_LVL  = 3'd4;
  localparam logic [LVL_W-1:0] SPI1_LVL = 3'd4;
  localparam logic [LVL_W-1:0] PWM2_LVL_RST = 3'd6;
  localparam logic [LVL_W-1:0] PWM2_LVL_MIN = 3'd1;
  localparam logic [LVL_W-1:0] PWM2_LVL_MAX = 3'd6;
endpackage

// File: rtl/irq_line.sv
module irq_line #(
  parameter int SYNC_STAGES = 2,
  parameter bit EDGE_OK     = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic status_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic level;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], req_i};
  end
  assign level = sync_q[SYNC_STAGES-1];

  if (EDGE_OK) begin : g_edge
    logic prev_q, flag_q, edge_det;
    assign edge_det = level & ~prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        flag_q <= 1'b0;
      end else begin
        prev_q <= level;
        if (!edge_mode_i)  flag_q <= 1'b0;
        else if (edge_det) flag_q <= 1'b1;   // edge beats clear
        else if (clr_i)    flag_q <= 1'b0;
      end
    end
    assign status_o = edge_mode_i ? flag_q : level;

    assert_edge_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_mode_i && flag_q && !clr_i) |=> (flag_q || !edge_mode_i));
    assert_edge_win_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_mode_i && edge_det && clr_i) |=> (flag_q || !edge_mode_i));
    assert_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_mode_i && clr_i && !edge_det) |=> !flag_q);
  end else begin : g_level
    logic unused_cfg;
    assign unused_cfg = ^{edge_mode_i, clr_i};
    assign status_o   = level;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N     = 8,
  parameter int LVL_W = 3
) (
  input  logic [N-1:0]       req_i,
  input  logic [N*LVL_W-1:0] lvl_i,
  output logic [LVL_W-1:0]   lvl_o
);
  always_comb begin
    lvl_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (lvl_i[i*LVL_W +: LVL_W] > lvl_o))
        lvl_o = lvl_i[i*LVL_W +: LVL_W];
    end
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [STAT_W-1:0] wdata_i,
  input  logic [NUM_EXT-1:0] ext_irq_i,
  input  logic [NUM_EXT-1:0] edge_mode_i,
  input  logic              rtc_req_i,
  input  logic              spi1_req_i,
  input  logic              pwm2_req_i,
  input  logic              pwm2_lvl_we_i,
  input  logic [LVL_W-1:0]  pwm2_lvl_i,
  output logic [STAT_W-1:0] status_o,
  output logic [LVL_W-1:0]  prio_o
);
  logic                   wr;
  logic [NUM_EXT-1:0]     ext_stat;
  logic [LVL_W-1:0]       pwm_lvl_q;
  logic [NUM_SRC-1:0]     src_req;
  logic [NUM_SRC*LVL_W-1:0] src_lvl;
  logic                   unused_wdata;

  assign wr = sel_i & we_i;
  assign unused_wdata = ^wdata_i;

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    irq_line #(
      .SYNC_STAGES(SYNC_STAGES),
      .EDGE_OK    (EXT_EDGE_OK[i])
    ) u_line (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (ext_irq_i[i]),
      .edge_mode_i(edge_mode_i[i]),
      .clr_i      (wr & wdata_i[EXT_POS[i]]),
      .status_o   (ext_stat[i])
    );
    assign src_req[i] = ext_stat[i];
    assign src_lvl[i*LVL_W +: LVL_W] = LVL_W'(EXT_LVL[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_lvl_q <= PWM2_LVL_RST;
    else if (pwm2_lvl_we_i && pwm2_lvl_i >= PWM2_LVL_MIN && pwm2_lvl_i <= PWM2_LVL_MAX)
      pwm_lvl_q <= pwm2_lvl_i;
  end

  assign src_req[NUM_EXT]   = rtc_req_i;
  assign src_req[NUM_EXT+1] = spi1_req_i;
  assign src_req[NUM_EXT+2] = pwm2_req_i;
  assign src_lvl[NUM_EXT*LVL_W     +: LVL_W] = RTC_LVL;
  assign src_lvl[(NUM_EXT+1)*LVL_W +: LVL_W] = SPI1_LVL;
  assign src_lvl[(NUM_EXT+2)*LVL_W +: LVL_W] = pwm_lvl_q;

  always_comb begin
    status_o = '0;
    for (int i = 0; i < NUM_EXT; i++) status_o[EXT_POS[i]] = ext_stat[i];
    status_o[POS_RTC]  = rtc_req_i;
    status_o[POS_SPI1] = spi1_req_i;
    status_o[POS_PWM2] = pwm2_req_i;
  end

  irq_prio_enc #(.N(NUM_SRC), .LVL_W(LVL_W)) u_prio (
    .req_i(src_req),
    .lvl_i(src_lvl),
    .lvl_o(prio_o)
  );

  assert_prio_any_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o != '0) == (prio_o != '0)));
  assert_lvl_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_lvl_q >= PWM2_LVL_MIN && pwm_lvl_q <= PWM2_LVL_MAX));
  assert_lvl_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm2_lvl_we_i && (pwm2_lvl_i < PWM2_LVL_MIN || pwm2_lvl_i > PWM2_LVL_MAX))
      |=> $stable(pwm_lvl_q));
  assert_rsvd_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[15:14] == 2'b00));
endmodule

// File: tb/irq_status_reg_bench.sv
module irq_status_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 0, we = 0;
  logic [31:0] wdata = '0;
  logic [4:0]  ext = '0, emode = '0;
  logic        rtc = 0, spi = 0, pwm = 0, lvl_we = 0;
  logic [2:0]  lvl = '0;
  logic [31:0] status;
  logic [2:0]  prio;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_status_reg u_irq_status_reg (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .wdata_i(wdata),
    .ext_irq_i(ext), .edge_mode_i(emode), .rtc_req_i(rtc), .spi1_req_i(spi),
    .pwm2_req_i(pwm), .pwm2_lvl_we_i(lvl_we), .pwm2_lvl_i(lvl),
    .status_o(status), .prio_o(prio)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle(); repeat (3) @(posedge clk); @(negedge clk); endtask

  task automatic wr(input logic s, input logic [31:0] d);
    @(negedge clk); sel = s; we = 1; wdata = d;
    @(posedge clk); @(negedge clk); sel = 0; we = 0; wdata = '0;
  endtask

  task automatic set_lvl(input logic [2:0] v);
    @(negedge clk); lvl_we = 1; lvl = v;
    @(posedge clk); @(negedge clk); lvl_we = 0;
  endtask

  task automatic t_reset();
    chk("R1 status", status, 32'h0);
    chk("R1 prio", {29'b0, prio}, 32'h0);
  endtask

  task automatic t_periph();
    @(negedge clk); rtc = 1; #1 chk("R2 rtc bit22", status, 32'h0040_0000);
    chk("R8 rtc lvl4", {29'b0, prio}, 32'd4);
    rtc = 0; spi = 1; #1 chk("R2 spi bit21", status, 32'h0020_0000);
    spi = 0; pwm = 1; #1 chk("R2 pwm bit13", status, 32'h0000_2000);
    chk("R1 pwm default lvl6", {29'b0, prio}, 32'd6);
    rtc = 1; spi = 1;
    wr(1, 32'h0060_2000);
    chk("R11 periph write ignored", status, 32'h0060_2000);
    rtc = 0; spi = 0; pwm = 0;
  endtask

  task automatic t_reserved();
    @(negedge clk); ext = 5'h1F; rtc = 1; spi = 1; pwm = 1;
    settle();
    wr(1, 32'hFFFF_FFFF);
    chk("R3 only defined bits", status, 32'h007F_2000);
    ext = '0; rtc = 0; spi = 0; pwm = 0;
    settle();
    chk("R3 all idle", status, 32'h0);
  endtask

  task automatic t_level();
    @(negedge clk); ext[0] = 1;
    @(posedge clk); @(negedge clk);
    chk("R4 one clock not yet", status, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R4 pin1 bit16", status, 32'h0001_0000);
    wr(1, 32'h0001_0000);
    chk("R4 write no clear", status, 32'h0001_0000);
    ext[0] = 0; settle();
    chk("R4 follows pin low", status, 32'h0);
  endtask

  task automatic t_edge();
    @(negedge clk); emode[2] = 1; ext[2] = 1;
    settle();
    chk("R5 pin3 edge bit18", status, 32'h0004_0000);
    ext[2] = 0; settle();
    chk("R5 held after fall", status, 32'h0004_0000);
  endtask

  task automatic t_clear();
    wr(1, 32'h0);
    chk("R6 write 0 no effect", status, 32'h0004_0000);
    wr(0, 32'hFFFF_FFFF);
    chk("R6 unselected ignored", status, 32'h0004_0000);
    wr(1, 32'h0004_0000);
    chk("R6 write 1 clears", status, 32'h0);
    emode[2] = 0;
  endtask

  task automatic t_race();
    @(negedge clk); emode[4] = 1; ext[4] = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); sel = 1; we = 1; wdata = 32'h0008_0000;
    @(posedge clk); @(negedge clk); sel = 0; we = 0; wdata = '0;
    chk("R7 edge beats clear pin6", status, 32'h0008_0000);
    wr(1, 32'h0008_0000);
    chk("R6 pin6 cleared later", status, 32'h0);
    ext[4] = 0; emode[4] = 0; settle();
  endtask

  task automatic t_irq5();
    @(negedge clk); emode = 5'h1F; ext[3] = 1;
    settle();
    chk("R10 pin5 bit20", status, 32'h0010_0000);
    ext[3] = 0; settle();
    chk("R10 pin5 stays level", status, 32'h0);
    emode = '0;
  endtask

  task automatic t_prio();
    chk("R8 none", {29'b0, prio}, 32'd0);
    @(negedge clk); ext[0] = 1; settle();
    chk("R8 pin1", {29'b0, prio}, 32'd1);
    ext[2] = 1; settle();
    chk("R8 pin1+pin3", {29'b0, prio}, 32'd3);
    spi = 1; #1 chk("R8 spi over pin3", {29'b0, prio}, 32'd4);
    ext[4] = 1; settle();
    chk("R8 pin6 top", {29'b0, prio}, 32'd6);
    ext = '0; spi = 0; settle();
    chk("R8 back to none", {29'b0, prio}, 32'd0);
  endtask

  task automatic t_pwm_lvl();
    set_lvl(3'd2); pwm = 1; #1
    chk("R9 lvl 2", {29'b0, prio}, 32'd2);
    set_lvl(3'd0); #1 chk("R9 0 ignored", {29'b0, prio}, 32'd2);
    set_lvl(3'd7); #1 chk("R9 7 ignored", {29'b0, prio}, 32'd2);
    set_lvl(3'd5); #1 chk("R9 lvl 5", {29'b0, prio}, 32'd5);
    ext[2] = 1; settle();
    chk("R9 pwm5 over pin3", {29'b0, prio}, 32'd5);
    set_lvl(3'd1); #1 chk("R9 pin3 over pwm1", {29'b0, prio}, 32'd3);
    ext = '0; pwm = 0; settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_periph();
    t_reserved();
    t_level();
    t_edge();
    t_clear();
    t_race();
    t_irq5();
    t_prio();
    t_pwm_lvl();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule